// File: doc/BRIEF.md
# RS(528,514) Systematic Encoder over GF(2^10)

This block adds forward error correction to a transcoded serial data path. It takes 257-bit transcoded words on a valid/ready input. It slices the concatenated bit stream into 10-bit symbols and streams those symbols out unchanged. After every 514 message symbols it appends 14 parity symbols computed over GF(2^10).

The 20 input words of one codeword hold 5140 bits, which is exactly 514 symbols, so every codeword starts on a word boundary. A full codeword is 5280 bits, the same size as the 80 line blocks it protects, so the line rate does not change. The encoder treats its input as opaque bits and does not know where packets start or end.

The output is one 10-bit symbol per cycle while valid is high. A marker flags the first symbol of each codeword. The output has no backpressure. Input ready drops while parity is being emitted.

Top module: `rs528_encoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `sym_valid_o` is 0 and `word_ready_o` is 1.
- R2: Word bit 0 is the earliest bit of each word, and words follow one another in acceptance order. Message symbol s of a codeword carries stream bits 10s..10s+9 of that codeword, with stream bit 10s in symbol bit 0.
- R3: Each codeword is emitted as 528 symbols: the 514 message symbols in order, then 14 parity symbols. `sym_first_o` is 1 on message symbol 0 only.
- R4: The field is GF(2^10) with the primitive polynomial x^10+x^3+1, and alpha is the root 0x002. The generator is g(x) = product of (x + alpha^i) for i = 0..13. Message symbol 0 is the highest-degree coefficient of m(x). The parity is the remainder of m(x)·x^14 divided by g(x), emitted highest degree first. The complete codeword therefore evaluates to zero at alpha^0..alpha^13.
- R5: Exactly 20 words are accepted per codeword. `word_ready_o` is 0 from the last message symbol until the parity has been emitted. The 14 parity symbols follow the last message symbol on consecutive cycles.
- R6: Any input bit pattern, including all zeros and all ones, is encoded by the same rule. Idle cycles between words do not change any output symbol. An all-zero message gives all-zero parity.
- R7: A reset in the middle of a codeword discards that partial codeword. The next codeword is encoded as if nothing had preceded it.
- R8: The parity state is cleared at every codeword start, so codewords sent back to back are encoded independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_i | input | 257 | Transcoded input word, bit 0 earliest |
| word_valid_i | input | 1 | Input word is valid |
| word_ready_o | output | 1 | Encoder accepts a word this cycle |
| sym_o | output | 10 | Output symbol |
| sym_valid_o | output | 1 | Output symbol is valid |
| sym_first_o | output | 1 | Output symbol is message symbol 0 of a codeword |

## Verification
A corrupted parity register shows up only in the 14 parity symbols at the end of the codeword it occurred in. The bench catches it by comparing those symbols with a long division and with the syndromes of the received codeword, up to about 540 cycles after the fault. A slipped bit-buffer count or word count shows up earlier, as a misplaced message symbol, a start marker in the wrong place, or ready asserted during the parity tail. A parity register that is not cleared shows up in the first codeword that follows.

// File: rtl/rs528_pkg.sv
package rs528_pkg;
    localparam int SYM_W        = 10;
    localparam int MSG_SYMS     = 514;
    localparam int PAR_SYMS     = 14;
    localparam int WORD_W       = 257;
    localparam int WORDS_PER_CW = 20;
    localparam logic [SYM_W:0] FIELD_POLY = 11'h409;

    localparam int SCNT_W = $clog2(MSG_SYMS);
    localparam int WCNT_W = $clog2(WORDS_PER_CW + 1);
    localparam int PCNT_W = $clog2(PAR_SYMS);

    typedef logic [SYM_W-1:0] sym_t;
    typedef enum logic {PH_MSG, PH_PAR} phase_e;

    // product of two field elements, shift-and-add with reduction
    function automatic sym_t gf_mul(sym_t a, sym_t b);
        logic [SYM_W:0] sh;
        sym_t acc;
        acc = '0;
        sh  = {1'b0, a};
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc ^= sh[SYM_W-1:0];
            sh = sh << 1;
            if (sh[SYM_W]) sh ^= FIELD_POLY;
        end
        return acc;
    endfunction

    // low coefficients of the monic generator, coefficient j at [j*SYM_W +: SYM_W]
    function automatic logic [PAR_SYMS*SYM_W-1:0] gen_poly();
        sym_t g [PAR_SYMS+1];
        sym_t root;
        logic [PAR_SYMS*SYM_W-1:0] packed_g;
        for (int j = 0; j <= PAR_SYMS; j++) g[j] = '0;
        g[0] = sym_t'(1);
        root = sym_t'(1);
        for (int i = 0; i < PAR_SYMS; i++) begin
            for (int j = PAR_SYMS; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
            g[0] = gf_mul(g[0], root);
            root = gf_mul(root, sym_t'(2));
        end
        for (int j = 0; j < PAR_SYMS; j++) packed_g[j*SYM_W +: SYM_W] = g[j];
        return packed_g;
    endfunction
endpackage

// File: rtl/rs528_packer.sv
module rs528_packer
    import rs528_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              allow_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              valid_i,
    output logic              ready_o,
    output logic              take_o,
    output sym_t              sym_o,
    output logic              sym_valid_o
);
    localparam int BITS_W = WORD_W + SYM_W - 1;
    localparam int CNT_W  = $clog2(BITS_W + 1);

    typedef struct packed {
        logic [BITS_W-1:0] bits;
        logic [CNT_W-1:0]  cnt;
    } pk_state_t;

    pk_state_t st_d, st_q;
    logic              emit;
    logic [CNT_W-1:0]  rem;
    logic [BITS_W-1:0] kept;

    always_comb begin
        st_d        = st_q;
        emit        = (st_q.cnt >= CNT_W'(SYM_W));
        ready_o     = allow_i && (st_q.cnt < CNT_W'(2 * SYM_W));
        take_o      = ready_o && valid_i;
        sym_o       = st_q.bits[SYM_W-1:0];
        sym_valid_o = emit;
        kept        = emit ? (st_q.bits >> SYM_W) : st_q.bits;
        rem         = emit ? (st_q.cnt - CNT_W'(SYM_W)) : st_q.cnt;
        st_d.bits   = kept;
        st_d.cnt    = rem;
        if (take_o) begin
            st_d.bits = kept | (BITS_W'(word_i) << rem);
            st_d.cnt  = rem + CNT_W'(WORD_W);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rs528_parity.sv
module rs528_parity
    import rs528_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic feed_i,
    input  sym_t sym_i,
    input  logic shift_i,
    output sym_t top_o
);
    localparam logic [PAR_SYMS*SYM_W-1:0] GEN = gen_poly();

    typedef struct packed {
        sym_t [PAR_SYMS-1:0] p;
    } par_state_t;

    par_state_t st_d, st_q;
    sym_t fb;
    sym_t prod [PAR_SYMS];

    assign fb    = sym_i ^ st_q.p[PAR_SYMS-1];
    assign top_o = st_q.p[PAR_SYMS-1];

    for (genvar j = 0; j < PAR_SYMS; j++) begin : g_tap
        assign prod[j] = gf_mul(fb, GEN[j*SYM_W +: SYM_W]);
    end

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (feed_i) begin
            st_d.p[0] = prod[0];
            for (int j = 1; j < PAR_SYMS; j++) st_d.p[j] = st_q.p[j-1] ^ prod[j];
        end else if (shift_i) begin
            st_d.p[0] = '0;
            for (int j = 1; j < PAR_SYMS; j++) st_d.p[j] = st_q.p[j-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rs528_encoder.sv
module rs528_encoder
    import rs528_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [rs528_pkg::WORD_W-1:0] word_i,
    input  logic                        word_valid_i,
    output logic                        word_ready_o,
    output logic [rs528_pkg::SYM_W-1:0]  sym_o,
    output logic                        sym_valid_o,
    output logic                        sym_first_o
);
    typedef struct packed {
        phase_e             phase;
        logic [SCNT_W-1:0]  sym_cnt;
        logic [WCNT_W-1:0]  word_cnt;
        logic [PCNT_W-1:0]  par_cnt;
        sym_t               out_sym;
        logic               out_valid;
        logic               out_first;
    } enc_state_t;

    enc_state_t st_d, st_q;
    logic allow, take, pk_valid, feed, shift, clr, in_parity;
    sym_t pk_sym, par_top;

    assign allow     = (st_q.phase == PH_MSG) && (st_q.word_cnt < WCNT_W'(WORDS_PER_CW));
    assign in_parity = (st_q.phase == PH_PAR);

    rs528_packer i_packer (
        .clk         (clk),
        .rst_n       (rst_n),
        .allow_i     (allow),
        .word_i      (word_i),
        .valid_i     (word_valid_i),
        .ready_o     (word_ready_o),
        .take_o      (take),
        .sym_o       (pk_sym),
        .sym_valid_o (pk_valid)
    );

    rs528_parity i_parity (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .feed_i  (feed),
        .sym_i   (pk_sym),
        .shift_i (shift),
        .top_o   (par_top)
    );

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        st_d.out_first = 1'b0;
        feed           = 1'b0;
        shift          = 1'b0;
        clr            = 1'b0;
        if (take) st_d.word_cnt = st_q.word_cnt + WCNT_W'(1);
        case (st_q.phase)
            PH_MSG: begin
                if (pk_valid) begin
                    feed           = 1'b1;
                    st_d.out_sym   = pk_sym;
                    st_d.out_valid = 1'b1;
                    st_d.out_first = (st_q.sym_cnt == '0);
                    if (st_q.sym_cnt == SCNT_W'(MSG_SYMS - 1)) begin
                        st_d.phase   = PH_PAR;
                        st_d.sym_cnt = '0;
                    end else begin
                        st_d.sym_cnt = st_q.sym_cnt + SCNT_W'(1);
                    end
                end
            end
            default: begin
                shift          = 1'b1;
                st_d.out_sym   = par_top;
                st_d.out_valid = 1'b1;
                if (st_q.par_cnt == PCNT_W'(PAR_SYMS - 1)) begin
                    clr           = 1'b1;
                    st_d.phase    = PH_MSG;
                    st_d.par_cnt  = '0;
                    st_d.word_cnt = '0;
                end else begin
                    st_d.par_cnt = st_q.par_cnt + PCNT_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sym_o       = st_q.out_sym;
    assign sym_valid_o = st_q.out_valid;
    assign sym_first_o = st_q.out_first;
endmodule

// File: rtl/rs528_encoder_chk.sv
module rs528_encoder_chk
    import rs528_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              word_ready_o,
    input logic              sym_valid_o,
    input logic              sym_first_o,
    input logic              in_parity,
    input logic [SCNT_W-1:0] sym_cnt,
    input logic [WCNT_W-1:0] word_cnt
);
    assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !sym_valid_o);

    assert_first_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sym_first_o |-> sym_valid_o);

    assert_sym_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sym_cnt < SCNT_W'(MSG_SYMS));

    assert_no_ready_in_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_parity |-> !word_ready_o);

    assert_parity_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_parity |=> sym_valid_o);

    assert_word_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_cnt <= WCNT_W'(WORDS_PER_CW));
endmodule

bind rs528_encoder rs528_encoder_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_ready_o (word_ready_o),
    .sym_valid_o  (sym_valid_o),
    .sym_first_o  (sym_first_o),
    .in_parity    (in_parity),
    .sym_cnt      (st_q.sym_cnt),
    .word_cnt     (st_q.word_cnt)
);

// File: tb/test_rs528_encoder.sv
module test_rs528_encoder;
    localparam int W = 257, NW = 20, NS = 514, NP = 14, NCW = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [W-1:0]   word_i;
    logic           word_valid_i;
    logic           word_ready_o;
    logic [9:0]     sym_o;
    logic           sym_valid_o;
    logic           sym_first_o;

    int checks = 0, errors = 0, cycles = 0;
    logic [W-1:0] stim [NCW*NW];
    int gen [NP+1];
    int got [NS+NP];
    int idx = 0, cw_done = 0;
    bit tail_bad = 0, ready_bad = 0, first_bad = 0;

    always #10 clk = ~clk;

    rs528_encoder i_rs528_encoder (
        .clk(clk), .rst_n(rst_n), .word_i(word_i), .word_valid_i(word_valid_i),
        .word_ready_o(word_ready_o), .sym_o(sym_o), .sym_valid_o(sym_valid_o),
        .sym_first_o(sym_first_o)
    );

    function automatic int gfm(int a, int b);
        int r = 0;
        for (int i = 0; i < 10; i++) begin
            if (((b >> i) & 1) != 0) r ^= a;
            a = a << 1;
            if ((a & 'h400) != 0) a ^= 'h409;
        end
        return r & 'h3ff;
    endfunction

    function automatic void build_gen();
        int root = 1;
        for (int j = 0; j <= NP; j++) gen[j] = 0;
        gen[0] = 1;
        for (int i = 0; i < NP; i++) begin
            for (int j = NP; j >= 1; j--) gen[j] = gen[j-1] ^ gfm(gen[j], root);
            gen[0] = gfm(gen[0], root);
            root = gfm(root, 2);
        end
    endfunction

    function automatic int exp_msg(int cw, int s);
        int v = 0;
        for (int k = 0; k < 10; k++) begin
            int pos = s * 10 + k;
            if (stim[cw*NW + pos / W][pos % W]) v |= (1 << k);
        end
        return v;
    endfunction

    function automatic logic [W-1:0] rnd_word();
        logic [W-1:0] w = '0;
        for (int k = 0; k < 9; k++) w = (w << 32) | W'($urandom());
        return w;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic finish_cw();
        int c [NS+NP];
        int mism = 0, ma = 0, me = 0, pm = 0, pa = 0, pe = 0, syn_bad = 0, syn_v = 0;
        int slot = cw_done;
        if (slot >= NCW) begin
            check(0, "R3", "extra codeword", slot, NCW - 1);
            return;
        end
        for (int s = 0; s < NS; s++) begin
            int e = exp_msg(slot, s);
            c[NS+NP-1-s] = e;
            if (got[s] != e) begin
                if (mism == 0) begin ma = got[s]; me = e; end
                mism++;
            end
        end
        for (int d = 0; d < NP; d++) c[d] = 0;
        for (int d = NS+NP-1; d >= NP; d--) begin
            int co = c[d];
            if (co != 0) for (int j = 0; j <= NP; j++) c[d-NP+j] ^= gfm(co, gen[j]);
        end
        for (int i = 0; i < NP; i++) begin
            if (got[NS+i] != c[NP-1-i]) begin
                if (pm == 0) begin pa = got[NS+i]; pe = c[NP-1-i]; end
                pm++;
            end
        end
        for (int i = 0, r = 1; i < NP; i++, r = gfm(r, 2)) begin
            int acc = 0;
            for (int k = 0; k < NS+NP; k++) acc = gfm(acc, r) ^ got[k];
            if (acc != 0) begin syn_bad++; syn_v = acc; end
        end
        check(mism == 0, "R2", "message symbol", ma, me);
        check(pm == 0, "R4", "parity symbol vs division", pa, pe);
        check(syn_bad == 0, "R4", "codeword syndrome", syn_v, 0);
        check(!tail_bad, "R5", "parity symbols not consecutive", tail_bad, 0);
        check(!ready_bad, "R5", "ready high during parity tail", ready_bad, 0);
        check(!first_bad, "R3", "first marker placement", first_bad, 0);
        if (slot == 0) check(pm == 0 && got[NS] == 0 && got[NS+NP-1] == 0, "R6", "zero message parity", got[NS], 0);
        if (slot == 1) check(mism == 0 && pm == 0, "R6", "all-ones codeword", mism + pm, 0);
        if (slot == 3) check(mism == 0 && pm == 0, "R7", "codeword after mid-codeword reset", mism + pm, 0);
        if (slot >= 6) check(mism == 0 && pm == 0, "R8", "back-to-back codeword", mism + pm, 0);
        cw_done++;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            idx = 0; tail_bad = 0; ready_bad = 0; first_bad = 0;
        end else begin
            if (idx >= NS && idx < NS+NP && !sym_valid_o) tail_bad = 1;
            if (sym_valid_o) begin
                if (sym_first_o != (idx == 0)) first_bad = 1;
                if (idx >= NS-1 && idx <= NS+NP-2 && word_ready_o) ready_bad = 1;
                got[idx] = int'(sym_o);
                idx++;
                if (idx == NS+NP) begin
                    finish_cw();
                    idx = 0; tail_bad = 0; ready_bad = 0; first_bad = 0;
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual %0d expected %0d", cw_done, NCW);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic send(input logic [W-1:0] w, input int gap);
        repeat (gap) @(negedge clk);
        word_i = w;
        word_valid_i = 1'b1;
        while (!word_ready_o) @(negedge clk);
        @(negedge clk);
        word_valid_i = 1'b0;
    endtask

    task automatic send_slot(int slot, int maxgap);
        for (int n = 0; n < NW; n++)
            send(stim[slot*NW + n], (maxgap == 0) ? 0 : int'($urandom_range(maxgap, 0)));
    endtask

    initial begin
        rst_n = 1'b0;
        word_valid_i = 1'b0;
        word_i = '0;
        void'($urandom(32'd2024));
        build_gen();
        for (int n = 0; n < NCW*NW; n++) stim[n] = rnd_word();
        for (int n = 0; n < NW; n++) begin
            stim[0*NW + n] = '0;
            stim[1*NW + n] = '1;
            stim[2*NW + n] = '0;
            stim[3*NW + n] = '0;
        end
        stim[2*NW][0] = 1'b1;
        stim[3*NW + NW - 1][W-1] = 1'b1;

        repeat (3) @(negedge clk);
        check(!sym_valid_o, "R1", "valid during reset", sym_valid_o, 0);
        rst_n = 1'b1;
        check(!sym_valid_o, "R1", "valid after reset", sym_valid_o, 0);
        check(word_ready_o, "R1", "ready after reset", word_ready_o, 1);

        send_slot(0, 0);
        send_slot(1, 3);
        send_slot(2, 0);
        for (int n = 0; n < 7; n++) send(rnd_word(), 0);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(!sym_valid_o, "R7", "valid after mid-codeword reset", sym_valid_o, 0);
        check(word_ready_o, "R1", "ready after mid-codeword reset", word_ready_o, 1);
        send_slot(3, 2);
        send_slot(4, 3);
        send_slot(5, 1);
        send_slot(6, 0);
        send_slot(7, 0);
        while (cw_done < NCW) @(negedge clk);
        repeat (20) @(negedge clk);
        check(cw_done == NCW, "R3", "codeword count", cw_done, NCW);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule